// File: doc/BRIEF.md
# E1 CRC-4 Intermediate Recalculator

This block sits at a midpoint on an E1 path. The serial stream that reaches it is already fully framed. Timeslot 0 already holds the frame alignment words, the multiframe alignment bits and valid or deliberately errored CRC-4 checksums. The block overwrites selected spare national (Sa) bits with new values. It then repairs the CRC-4 bits that follow, so that they match the altered data.

The repair does not recompute the checksum. The block runs CRC-4 (generator x^4 + x + 1) over the difference between the bits it emits and the bits it received, one submultiframe at a time. It XORs that remainder into the C1..C4 bits that arrive in the next submultiframe. Because CRC-4 is linear, a checksum error that was present upstream is still present downstream with the same syndrome.

The block takes one bit per clock. A pulse on the sync input marks the first bit of a CRC multiframe. Two enable inputs must both be high for the Sa rewrite to take effect, and their state is captured once per submultiframe.

Top module: `e1_crc4_recalc`

## Requirements
- R1: `ser_o` repeats `ser_i` two clock cycles later, for every bit that is neither an active Sa slot nor a C bit. This includes the FAS word, the multiframe alignment bits and timeslots 1 to 31.
- R2: A bit presented with `sync_i` high is bit 1 of timeslot 0 in frame 0 of a 16-frame multiframe. A frame is 256 bits. Frames 0–7 and 8–15 form the two submultiframes, and positions are counted from that bit.
- R3: Until the first `sync_i` pulse, every bit passes unchanged with the R1 latency, whatever the enables and Sa inputs are.
- R4: A submultiframe is active only if `recalc_en_i` and `crc_ins_en_i` are both high together with its first bit. A change of either enable later in the same submultiframe has no effect.
- R5: In an active submultiframe, within odd frames, the bit at timeslot-0 position 4+k (k = 0..4) is replaced by `sa_i[k]` if `sa_sel_i[k]` is high. Otherwise it is left as received. `sa_i` and `sa_sel_i` are taken in the same cycle as that bit.
- R6: C1..C4 sit in bit 1 of timeslot 0 of frames 0, 2, 4 and 6 of a submultiframe. Each output C bit equals the input C bit XOR the matching coefficient of the remainder of D(x)·x^4 divided by x^4+x+1. Here D is the 2048-bit difference between output and input over the previous submultiframe, and C1 takes the x^3 coefficient. If the input C bits were valid for the input data, the output C bits are valid for the output data.
- R7: An error pattern e present in the input C bits relative to the input data appears unchanged as e in the output C bits relative to the output data.
- R8: An inactive submultiframe leaves its Sa bits untouched and adds no correction to the next submultiframe. A correction owed by a preceding active submultiframe is still applied.
- R9: While `rst_ni` is low, `ser_o` is 0 and the block's alignment and correction state are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, one stream bit per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_i | input | 1 | Incoming framed E1 bit |
| sync_i | input | 1 | High with the first bit of a CRC multiframe |
| recalc_en_i | input | 1 | Recalculation mode enable |
| crc_ins_en_i | input | 1 | CRC-4 insertion enable; needed together with recalc_en_i |
| sa_i | input | SA_W | New Sa values; bit k feeds timeslot-0 position 4+k |
| sa_sel_i | input | SA_W | Per-Sa-bit replace select |
| ser_o | output | 1 | Outgoing stream, two cycles behind ser_i |

## Verification
Each submultiframe carries fresh random payload. Its input C bits are derived by long division over the previous input submultiframe, and some of them carry deliberate error patterns. The expected output C bits come from long division over the expected output, so the XOR-correction method is checked against a plain recomputation and errors that must survive are told apart from ones the block wrongly cleaned. Three Sa select patterns are used: all bits, none, and random per frame. Together they separate correct per-bit gating from whole-field rewriting. Enable patterns cover each enable low on its own, both low, and a toggle inside a submultiframe in both directions. These cases distinguish per-submultiframe mode capture from live gating and confirm that a correction carries into an inactive submultiframe. A random preamble before the first sync, with both enables high, shows that nothing is altered before alignment.

// File: rtl/e1_crc4r_pkg.sv
`timescale 1ns/1ps
package e1_crc4r_pkg;
  localparam int unsigned E1_BITS_PER_FRAME = 256;
  localparam int unsigned E1_FRAMES_PER_MF  = 16;
  localparam int unsigned E1_FRAMES_PER_SMF = 8;
  localparam int unsigned E1_SA_W           = 5;
  localparam int unsigned E1_SA_FIRST       = 3;  // zero-based position of Sa4
  localparam int unsigned CRC4_W            = 4;
  localparam logic [3:0]  CRC4_POLY         = 4'b0011;  // x^4 + x + 1, implicit x^4
endpackage

// File: rtl/e1_frame_tracker.sv
`timescale 1ns/1ps
module e1_frame_tracker #(
  parameter int unsigned BPF   = 256,
  parameter int unsigned FPM   = 16,
  parameter int unsigned BIT_W = $clog2(BPF),
  parameter int unsigned FRM_W = $clog2(FPM)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ser_i,
  input  logic             sync_i,
  output logic             ser_o,
  output logic [BIT_W-1:0] bit_o,
  output logic [FRM_W-1:0] frm_o,
  output logic             aligned_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ser_o     <= 1'b0;
      bit_o     <= '0;
      frm_o     <= '0;
      aligned_o <= 1'b0;
    end else begin
      ser_o     <= ser_i;
      aligned_o <= aligned_o | sync_i;
      if (sync_i) begin
        bit_o <= '0;
        frm_o <= '0;
      end else if (bit_o == BIT_W'(BPF-1)) begin
        bit_o <= '0;
        frm_o <= (frm_o == FRM_W'(FPM-1)) ? '0 : frm_o + 1'b1;
      end else begin
        bit_o <= bit_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/e1_sa_replacer.sv
`timescale 1ns/1ps
module e1_sa_replacer #(
  parameter int unsigned BIT_W    = 8,
  parameter int unsigned SA_W     = 5,
  parameter int unsigned SA_FIRST = 3
) (
  input  logic             ser_i,
  input  logic [BIT_W-1:0] bit_i,
  input  logic             odd_frame_i,
  input  logic             aligned_i,
  input  logic             mode_i,
  input  logic [SA_W-1:0]  sa_i,
  input  logic [SA_W-1:0]  sel_i,
  output logic             ser_o,
  output logic             diff_o
);
  logic [SA_W-1:0] hit;

  for (genvar k = 0; k < SA_W; k++) begin : g_slot
    assign hit[k] = aligned_i & odd_frame_i & mode_i & sel_i[k]
                  & (bit_i == BIT_W'(SA_FIRST + k));
  end

  always_comb begin
    ser_o  = (|hit) ? (|(hit & sa_i)) : ser_i;
    diff_o = ser_o ^ ser_i;
  end
endmodule

// File: rtl/e1_crc4_corrector.sv
`timescale 1ns/1ps
module e1_crc4_corrector #(
  parameter int unsigned BIT_W = 8,
  parameter int unsigned FRM_W = 4,
  parameter int unsigned FPS   = 8,
  parameter int unsigned CRC_W = 4,
  parameter logic [CRC_W-1:0] POLY = 4'b0011
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BIT_W-1:0] bit_i,
  input  logic [FRM_W-1:0] frm_i,
  input  logic             aligned_i,
  input  logic             rec_en_i,
  input  logic             ins_en_i,
  input  logic             diff_i,
  output logic             mode_o,
  output logic             fix_o
);
  localparam int unsigned SUB_W = $clog2(FPS);

  logic [SUB_W-1:0] sub;
  logic             smf_start, c_slot, fb;
  logic [CRC_W-1:0] acc_q, corr_q, corr_cur, base, acc_nxt;
  logic             mode_q;

  always_comb begin
    sub       = frm_i[SUB_W-1:0];
    smf_start = aligned_i && (bit_i == '0) && (sub == '0);
    c_slot    = aligned_i && (bit_i == '0) && !sub[0];
    mode_o    = smf_start ? (rec_en_i & ins_en_i) : mode_q;
    corr_cur  = smf_start ? acc_q : corr_q;
    fix_o     = c_slot & corr_cur[CRC_W-1-int'(sub[SUB_W-1:1])];
    // serial division of the difference stream, restarting each submultiframe
    base      = smf_start ? '0 : acc_q;
    fb        = base[CRC_W-1] ^ diff_i;
    acc_nxt   = {base[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      corr_q <= '0;
      mode_q <= 1'b0;
    end else begin
      acc_q  <= acc_nxt;
      mode_q <= mode_o;
      if (smf_start) corr_q <= acc_q;
    end
  end
endmodule

// File: rtl/e1_crc4_recalc.sv
`timescale 1ns/1ps
module e1_crc4_recalc
  import e1_crc4r_pkg::*;
#(
  parameter int unsigned BPF      = E1_BITS_PER_FRAME,
  parameter int unsigned FPM      = E1_FRAMES_PER_MF,
  parameter int unsigned FPS      = E1_FRAMES_PER_SMF,
  parameter int unsigned SA_W     = E1_SA_W,
  parameter int unsigned SA_FIRST = E1_SA_FIRST,
  parameter int unsigned CRC_W    = CRC4_W,
  parameter logic [CRC_W-1:0] POLY = CRC4_POLY
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ser_i,
  input  logic            sync_i,
  input  logic            recalc_en_i,
  input  logic            crc_ins_en_i,
  input  logic [SA_W-1:0] sa_i,
  input  logic [SA_W-1:0] sa_sel_i,
  output logic            ser_o
);
  localparam int unsigned BIT_W = $clog2(BPF);
  localparam int unsigned FRM_W = $clog2(FPM);

  logic             ser_q, aligned_q, rec_q, ins_q;
  logic [BIT_W-1:0] bit_q;
  logic [FRM_W-1:0] frm_q;
  logic [SA_W-1:0]  sa_q, sel_q;
  logic             mode_act, ser_sa, diff, fix;

  e1_frame_tracker #(.BPF(BPF), .FPM(FPM), .BIT_W(BIT_W), .FRM_W(FRM_W)) u_trk (
    .clk_i, .rst_ni, .ser_i, .sync_i,
    .ser_o(ser_q), .bit_o(bit_q), .frm_o(frm_q), .aligned_o(aligned_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sa_q  <= '0;
      sel_q <= '0;
      rec_q <= 1'b0;
      ins_q <= 1'b0;
    end else begin
      sa_q  <= sa_i;
      sel_q <= sa_sel_i;
      rec_q <= recalc_en_i;
      ins_q <= crc_ins_en_i;
    end
  end

  e1_sa_replacer #(.BIT_W(BIT_W), .SA_W(SA_W), .SA_FIRST(SA_FIRST)) u_sa (
    .ser_i(ser_q), .bit_i(bit_q), .odd_frame_i(frm_q[0]), .aligned_i(aligned_q),
    .mode_i(mode_act), .sa_i(sa_q), .sel_i(sel_q), .ser_o(ser_sa), .diff_o(diff)
  );

  e1_crc4_corrector #(.BIT_W(BIT_W), .FRM_W(FRM_W), .FPS(FPS), .CRC_W(CRC_W),
                      .POLY(POLY)) u_crc (
    .clk_i, .rst_ni, .bit_i(bit_q), .frm_i(frm_q), .aligned_i(aligned_q),
    .rec_en_i(rec_q), .ins_en_i(ins_q), .diff_i(diff),
    .mode_o(mode_act), .fix_o(fix)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ser_o <= 1'b0;
    else         ser_o <= ser_sa ^ fix;
  end
endmodule

// File: rtl/e1_crc4_recalc_chk.sv
`timescale 1ns/1ps
module e1_crc4_recalc_chk #(
  parameter int unsigned BIT_W    = 8,
  parameter int unsigned FRM_W    = 4,
  parameter int unsigned SA_W     = 5,
  parameter int unsigned SA_FIRST = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ser_i,
  input logic             sync_i,
  input logic [SA_W-1:0]  sa_i,
  input logic [SA_W-1:0]  sa_sel_i,
  input logic             ser_o,
  input logic [BIT_W-1:0] bit_i,
  input logic [FRM_W-1:0] frm_i,
  input logic             aligned_i,
  input logic             mode_i
);
  logic [1:0]       warm;
  logic [BIT_W-1:0] p_bit;
  logic [FRM_W-1:0] p_frm;
  logic             p_al, p_mode, in_d1, in_d2;
  logic [SA_W-1:0]  sa_d1, sa_d2, sel_d1, sel_d2;
  logic             sa_slot, c_slot, ready;
  int               k;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      warm <= '0; p_bit <= '0; p_frm <= '0; p_al <= 1'b0; p_mode <= 1'b0;
      in_d1 <= 1'b0; in_d2 <= 1'b0;
      sa_d1 <= '0; sa_d2 <= '0; sel_d1 <= '0; sel_d2 <= '0;
    end else begin
      if (warm != 2'd3) warm <= warm + 2'd1;
      p_bit <= bit_i; p_frm <= frm_i; p_al <= aligned_i; p_mode <= mode_i;
      in_d1 <= ser_i; in_d2 <= in_d1;
      sa_d1 <= sa_i; sa_d2 <= sa_d1; sel_d1 <= sa_sel_i; sel_d2 <= sel_d1;
    end
  end

  always_comb begin
    ready   = (warm == 2'd3);
    k       = int'(p_bit) - int'(SA_FIRST);
    sa_slot = p_al && p_frm[0] && (k >= 0) && (k < int'(SA_W));
    c_slot  = p_al && (p_bit == '0) && !p_frm[0];
  end

  AST_PLAIN_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready && !sa_slot && !c_slot) |-> (ser_o == in_d2));  // R1
  AST_PRE_SYNC_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready && !p_al) |-> (ser_o == in_d2));  // R3
  AST_SYNC_ORIGIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> (bit_i == '0 && frm_i == '0 && aligned_i));  // R2
  AST_ALIGN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aligned_i |=> aligned_i);  // R2
  AST_SA_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready && sa_slot && p_mode && sel_d2[k]) |-> (ser_o == sa_d2[k]));  // R5
  AST_SA_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready && sa_slot && !p_mode) |-> (ser_o == in_d2));  // R8
endmodule

bind e1_crc4_recalc e1_crc4_recalc_chk #(
  .BIT_W(BIT_W), .FRM_W(FRM_W), .SA_W(SA_W), .SA_FIRST(SA_FIRST)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ser_i(ser_i), .sync_i(sync_i),
  .sa_i(sa_i), .sa_sel_i(sa_sel_i), .ser_o(ser_o),
  .bit_i(bit_q), .frm_i(frm_q), .aligned_i(aligned_q), .mode_i(mode_act)
);

// File: tb/e1_crc4_recalc_test.sv
`timescale 1ns/1ps
module e1_crc4_recalc_test;
  localparam int SMF_BITS = 2048;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ser_i = 1'b0, sync_i = 1'b0, rec_en = 1'b0, ins_en = 1'b0;
  logic [4:0] sa_i = '0, sel_i = '0;
  logic       ser_o;

  always #5 clk = ~clk;

  e1_crc4_recalc uut (
    .clk_i(clk), .rst_ni(rst_ni), .ser_i(ser_i), .sync_i(sync_i),
    .recalc_en_i(rec_en), .crc_ins_en_i(ins_en), .sa_i(sa_i), .sa_sel_i(sel_i),
    .ser_o(ser_o)
  );

  typedef struct {int cyc; logic v; string tag;} item_t;
  item_t q[$];
  int cyc_cnt = 0, n_run = 0, n_fail = 0;
  logic [SMF_BITS-1:0] prev_in, prev_out;
  logic have_prev = 1'b0;

  always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

  task automatic chk(input logic act, input logic exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: ser_o=%b expected %b at cycle %0d", tag, act, exp, cyc_cnt);
    end
  endtask

  // monitor: output of a bit driven after edge m is read after edge m+2
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc + 2 == cyc_cnt) begin
      item_t it;
      it = q.pop_front();
      chk(ser_o, it.v, it.tag);
    end
  end

  task automatic drive(input logic d, input logic sy, input logic re, input logic ie,
                       input logic [4:0] sa, input logic [4:0] sel,
                       input logic e, input string tag);
    item_t it;
    @(negedge clk);
    ser_i = d; sync_i = sy; rec_en = re; ins_en = ie; sa_i = sa; sel_i = sel;
    it.cyc = cyc_cnt; it.v = e; it.tag = tag;
    q.push_back(it);
  endtask

  // remainder of M(x)*x^4 by x^4+x+1, C positions taken as zero
  function automatic logic [3:0] ref_crc(input logic [SMF_BITS-1:0] v);
    logic [3:0] r = '0;
    for (int j = 0; j < SMF_BITS + 4; j++) begin
      logic b, top;
      b = 1'b0;
      if (j < SMF_BITS && !((j % 256) == 0 && ((j / 256) % 2) == 0)) b = v[j];
      top = r[3];
      r = {r[2:0], b};
      if (top) r = r ^ 4'b0011;
    end
    return r;
  endfunction

  task automatic run_smf(input int s, input logic rec0, input logic ins0,
                         input logic flip, input logic [4:0] sel_fix,
                         input logic sel_rnd, input logic [3:0] err);
    logic [SMF_BITS-1:0] vin, vout;
    logic [4:0] sa_f [8];
    logic [4:0] sel_f [8];
    logic [3:0] c;
    logic active;
    active = rec0 & ins0;
    for (int f = 0; f < 8; f++) begin
      sa_f[f]  = 5'($urandom());
      sel_f[f] = sel_rnd ? 5'($urandom()) : sel_fix;
    end
    for (int j = 0; j < SMF_BITS; j++) vin[j] = 1'($urandom() % 2);
    if (have_prev) begin
      c = ref_crc(prev_in) ^ err;
      for (int i = 0; i < 4; i++) vin[i*512] = c[3-i];
    end
    vout = vin;
    if (active)
      for (int f = 1; f < 8; f += 2)
        for (int k = 0; k < 5; k++)
          if (sel_f[f][k]) vout[f*256+3+k] = sa_f[f][k];
    if (have_prev) begin
      c = ref_crc(prev_out) ^ err;
      for (int i = 0; i < 4; i++) vout[i*512] = c[3-i];
    end
    for (int j = 0; j < SMF_BITS; j++) begin
      logic re, cpos, sapos;
      string tag;
      re    = (flip && j >= 600) ? ~rec0 : rec0;
      cpos  = ((j % 256) == 0) && (((j / 256) % 2) == 0);
      sapos = (((j / 256) % 2) == 1) && ((j % 256) >= 3) && ((j % 256) < 8);
      if (cpos)       tag = (err != 4'd0) ? "R7" : "R6";
      else if (sapos) tag = flip ? "R4" : (active ? "R5" : "R8");
      else            tag = (s == 0) ? "R2" : "R1";
      drive(vin[j], (j == 0) && (s % 2 == 0), re, ins0,
            sa_f[j/256], sel_f[j/256], vout[j], tag);
    end
    prev_in = vin; prev_out = vout; have_prev = 1'b1;
  endtask

  logic wd_fired = 1'b0;
  initial begin
    #2_000_000;
    wd_fired = 1'b1;
    n_run++; n_fail++;
    $display("FAIL watchdog: run incomplete, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    ser_i = 1'b1;
    repeat (3) @(negedge clk);
    chk(ser_o, 1'b0, "R9");  // reset state
    @(negedge clk);
    rst_ni = 1'b1;
    // R3: unaligned preamble with enables high
    for (int j = 0; j < 300; j++) begin
      logic d;
      d = 1'($urandom() % 2);
      drive(d, 1'b0, 1'b1, 1'b1, 5'($urandom()), 5'h1F, d, "R3");
    end
    run_smf(0, 1, 1, 0, 5'h1F, 0, 4'h0);  // R2 first after sync
    run_smf(1, 1, 1, 0, 5'h00, 1, 4'h0);  // R5 random selects
    run_smf(2, 1, 0, 0, 5'h1F, 0, 4'h5);  // R8 owed correction, R7 error
    run_smf(3, 0, 1, 1, 5'h1F, 0, 4'h0);  // R4 enable rises late
    run_smf(4, 1, 1, 1, 5'h1F, 0, 4'hA);  // R4 enable drops late
    run_smf(5, 1, 1, 0, 5'h00, 0, 4'h0);  // R5 nothing selected
    run_smf(6, 1, 1, 0, 5'h1F, 0, 4'hF);  // R7
    run_smf(7, 1, 1, 0, 5'h00, 1, 4'h3);
    run_smf(8, 0, 0, 0, 5'h1F, 0, 4'h0);  // R8
    run_smf(9, 1, 1, 0, 5'h1F, 0, 4'h6);
    repeat (4) @(negedge clk);
    if (!wd_fired) begin
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule